// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits on the bus of a 16-bit processor with a 64 KB address space and turns each bus access into one region select plus, for RAM regions, a 17-bit physical RAM address. It tells instruction fetches apart from data accesses through a code/data flag. In the bottom 16 KB the two kinds of access resolve differently. Fetches always land in the boot ROM. Data accesses land either in the boot ROM or in one of seven 8 KB RAM banks, chosen by a lower page register. The lowest 256 bytes are a processor register window that overrides everything else.

Above that are three more regions. One is a fixed 16 KB common RAM for code and data. One is a 16 KB window onto one of three RAM pages, chosen by an upper page register. The last is the I/O region. Both page registers are loaded through a small write port on the clock edge. The decode itself is purely combinational.

The physical RAM layout is as follows. Common RAM sits at 0x00000–0x03FFF. Upper pages 1..3 sit at page×0x4000. Lower banks 1..7 sit at 0x10000 + (bank−1)×0x2000.

Top module: `bank_addr_decoder`

## Requirements
- R1: Any strobed access with address 0000h–00FFh asserts the register window select (regionSel bit 0), regardless of the code/data flag and page values.
- R2: A strobed code fetch (isCode=1) at 0100h–3FFFh asserts the boot ROM select (bit 1), whatever the lower page.
- R3: A strobed data access (isCode=0) at 0100h–3FFFh with lower page 0 asserts the boot ROM select (bit 1).
- R4: A strobed data access at 0100h–3FFFh with lower page k in 1..7 asserts the banked RAM select (bit 2). ramAddr is 0x10000 + (k−1)×0x2000 + addr[12:0], so 2000h–3FFFh mirrors 0000h–1FFFh of the bank.
- R5: A strobed access at 4000h–7FFFh of either type asserts the common RAM select (bit 3), with ramAddr = addr[13:0].
- R6: A strobed access at 8000h–BFFFh of either type asserts the paged RAM select (bit 4), with ramAddr = upperPage×0x4000 + addr[13:0].
- R7: A strobed access at C000h–FFFFh asserts the I/O select (bit 5).
- R8: Exactly one bit of regionSel is set while rdStb or wrStb is high. All bits are zero when both are low. ramAddr is zero whenever no RAM select (bits 2..4) is set.
- R9: After reset the lower page is 0 and the upper page is 1.
- R10: On a clock edge with pageWe=1, pageIsUpper=0 loads the lower page from pageData[2:0], and pageIsUpper=1 loads the upper page from pageData[1:0]. An upper value of 0 is ignored and the old page is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor bus address |
| isCode | input | 1 | 1 = instruction fetch, 0 = data access |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| pageWe | input | 1 | Page register write enable |
| pageIsUpper | input | 1 | 1 = write upper page, 0 = write lower page |
| pageData | input | 3 | Page number to load |
| regionSel | output | 6 | One-hot region select: 0 reg window, 1 boot ROM, 2 banked RAM, 3 common RAM, 4 paged RAM, 5 I/O |
| ramAddr | output | 17 | Physical RAM address |

## Verification
The assertions watch on every cycle that the select is one-hot under a strobe and empty when idle. They also check that the register window wins in the lowest 256 bytes, that fetches in the bottom 16 KB never reach banked RAM, that the top quarter always decodes as I/O, and that ramAddr is zero outside RAM regions. Some behaviour only the bench scenarios can show, because it depends on page register history: the exact physical address for every bank and page, bank mirroring, the reset page values, and the rejection of an upper page value of 0.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int ADDR_W     = 16;
  localparam int PHYS_W     = 17;
  localparam int LO_PAGE_W  = 3;
  localparam int HI_PAGE_W  = 2;
  localparam int BANK_BITS  = 13;
  localparam int PAGE_BITS  = 14;
  localparam int REGION_CNT = 6;

  // Field order fixes regionSel bit positions: regWin is bit 0.
  typedef struct packed {
    logic ioSpace;
    logic pagedRam;
    logic commonRam;
    logic bankRam;
    logic bootRom;
    logic regWin;
  } regionStb_t;
endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import bank_addr_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 isCode,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [LO_PAGE_W-1:0] loPage,
  output regionStb_t           stb
);
  logic busActive;
  logic inRegWindow;

  assign busActive   = rdStb | wrStb;
  assign inRegWindow = (addr[ADDR_W-1:8] == '0);

  always_comb begin
    stb = '0;
    if (busActive) begin
      if (inRegWindow) begin
        stb.regWin = 1'b1;
      end else begin
        unique case (addr[ADDR_W-1:ADDR_W-2])
          2'd0: begin
            if (isCode || (loPage == '0)) stb.bootRom = 1'b1;
            else                          stb.bankRam = 1'b1;
          end
          2'd1: stb.commonRam = 1'b1;
          2'd2: stb.pagedRam  = 1'b1;
          default: stb.ioSpace = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bank_addr_dpath.sv
module bank_addr_dpath
  import bank_addr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pageWe,
  input  logic                 pageIsUpper,
  input  logic [LO_PAGE_W-1:0] pageData,
  input  logic [ADDR_W-1:0]    addr,
  input  regionStb_t           stb,
  output logic [LO_PAGE_W-1:0] loPage,
  output logic [PHYS_W-1:0]    ramAddr
);
  localparam logic [PHYS_W-1:0] BANK_BASE  = PHYS_W'(1) << (PHYS_W-1);
  localparam logic [HI_PAGE_W-1:0] HI_RESET = HI_PAGE_W'(1);

  logic [HI_PAGE_W-1:0] hiPage;
  logic [LO_PAGE_W-1:0] bankIdx;
  logic [PHYS_W-1:0]    bankOff;
  logic [PHYS_W-1:0]    pageOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loPage <= '0;
      hiPage <= HI_RESET;
    end else if (pageWe) begin
      if (!pageIsUpper)                        loPage <= pageData;
      else if (pageData[HI_PAGE_W-1:0] != '0)  hiPage <= pageData[HI_PAGE_W-1:0];
    end
  end

  assign bankIdx = loPage - LO_PAGE_W'(1);
  assign bankOff = PHYS_W'(bankIdx) << BANK_BITS;
  assign pageOff = PHYS_W'(hiPage) << PAGE_BITS;

  always_comb begin
    ramAddr = '0;
    if (stb.bankRam)
      ramAddr = BANK_BASE + bankOff + PHYS_W'(addr[BANK_BITS-1:0]);
    else if (stb.commonRam)
      ramAddr = PHYS_W'(addr[PAGE_BITS-1:0]);
    else if (stb.pagedRam)
      ramAddr = pageOff + PHYS_W'(addr[PAGE_BITS-1:0]);
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_addr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  isCode,
  input  logic                  rdStb,
  input  logic                  wrStb,
  input  logic                  pageWe,
  input  logic                  pageIsUpper,
  input  logic [LO_PAGE_W-1:0]  pageData,
  output logic [REGION_CNT-1:0] regionSel,
  output logic [PHYS_W-1:0]     ramAddr
);
  regionStb_t           stb;
  logic [LO_PAGE_W-1:0] loPage;

  bank_addr_ctrl u_ctrl (
    .addr   (addr),
    .isCode (isCode),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .loPage (loPage),
    .stb    (stb)
  );

  bank_addr_dpath u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .pageWe      (pageWe),
    .pageIsUpper (pageIsUpper),
    .pageData    (pageData),
    .addr        (addr),
    .stb         (stb),
    .loPage      (loPage),
    .ramAddr     (ramAddr)
  );

  assign regionSel = stb;
endmodule

// File: rtl/bank_addr_checker.sv
module bank_addr_checker
  import bank_addr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  isCode,
  input logic                  rdStb,
  input logic                  wrStb,
  input logic [REGION_CNT-1:0] regionSel,
  input logic [PHYS_W-1:0]     ramAddr
);
  assert_one_hot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb || wrStb) |-> ($countones(regionSel) == 1));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdStb && !wrStb) |-> (regionSel == '0));

  assert_ram_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regionSel[4:2] == 3'b000) |-> (ramAddr == '0));

  assert_reg_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdStb || wrStb) && addr[15:8] == 8'h00) |-> regionSel[0]);

  assert_fetch_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdStb || wrStb) && isCode && addr[15:14] == 2'b00 && addr[15:8] != 8'h00)
      |-> regionSel[1]);

  assert_io_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdStb || wrStb) && addr[15:14] == 2'b11) |-> regionSel[5]);
endmodule

bind bank_addr_decoder bank_addr_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .isCode    (isCode),
  .rdStb     (rdStb),
  .wrStb     (wrStb),
  .regionSel (regionSel),
  .ramAddr   (ramAddr)
);

// File: tb/bank_addr_decoder_tb.sv
`timescale 1ns/1ps
module bank_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        isCode = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic        pageWe = 1'b0, pageIsUpper = 1'b0;
  logic [2:0]  pageData = '0;
  logic [5:0]  regionSel;
  logic [16:0] ramAddr;

  int checks = 0;
  int fails = 0;
  logic [2:0] mLo = 3'd0;
  logic [1:0] mHi = 2'd1;

  always #2.5 clk = ~clk;

  bank_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .isCode(isCode),
    .rdStb(rdStb), .wrStb(wrStb), .pageWe(pageWe), .pageIsUpper(pageIsUpper),
    .pageData(pageData), .regionSel(regionSel), .ramAddr(ramAddr)
  );

  function automatic logic [5:0] expSel(logic [15:0] a, logic c, logic act, logic [2:0] lo);
    if (!act) return 6'b0;
    if (a[15:8] == 8'h00) return 6'b000001;
    case (a[15:14])
      2'd0: return (c || lo == 3'd0) ? 6'b000010 : 6'b000100;
      2'd1: return 6'b001000;
      2'd2: return 6'b010000;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [16:0] expAddr(logic [5:0] s, logic [15:0] a, logic [2:0] lo, logic [1:0] hi);
    if (s[2]) return 17'h10000 + 17'(lo - 3'd1) * 17'h2000 + 17'(a[12:0]);
    if (s[3]) return 17'(a[13:0]);
    if (s[4]) return 17'(hi) * 17'h4000 + 17'(a[13:0]);
    return 17'h0;
  endfunction

  function automatic string reqOf(logic [5:0] s);
    case (s)
      6'b000001: return "R1";
      6'b000010: return "R2/R3";
      6'b000100: return "R4";
      6'b001000: return "R5";
      6'b010000: return "R6";
      6'b100000: return "R7";
      default:   return "R8";
    endcase
  endfunction

  // Drive at negedge, check 1 ns later, before the next rising edge.
  task automatic access(input logic [15:0] a, input logic c, input logic rd, input logic wr, input string tag);
    logic [5:0]  es;
    logic [16:0] ea;
    @(negedge clk);
    addr = a; isCode = c; rdStb = rd; wrStb = wr;
    #1;
    es = expSel(a, c, rd | wr, mLo);
    ea = expAddr(es, a, mLo, mHi);
    checks++;
    if (regionSel !== es) begin
      fails++;
      $display("FAIL %s sel addr=%h code=%0d: actual %b expected %b", tag, a, c, regionSel, es);
    end
    checks++;
    if (ramAddr !== ea) begin
      fails++;
      $display("FAIL %s ramAddr addr=%h: actual %h expected %h", tag, a, ramAddr, ea);
    end
  endtask

  task automatic loadPage(input logic up, input logic [2:0] d);
    @(negedge clk);
    pageWe = 1'b1; pageIsUpper = up; pageData = d;
    @(posedge clk);
    #1;
    pageWe = 1'b0;
    // R10: model of page load; upper value 0 is ignored
    if (!up) mLo = d;
    else if (d[1:0] != 2'd0) mHi = d[1:0];
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: reset pages: data access in bottom region is ROM; paged window uses page 1
    access(16'h1234, 1'b0, 1'b1, 1'b0, "R9 lo reset");
    access(16'h8010, 1'b0, 1'b1, 1'b0, "R9 hi reset");
    // R8 idle
    access(16'h5000, 1'b0, 1'b0, 1'b0, "R8 idle");
    // R1 register window wins even with banked page
    loadPage(1'b0, 3'd5);
    access(16'h00FF, 1'b0, 1'b0, 1'b1, "R1");
    access(16'h0000, 1'b1, 1'b1, 1'b0, "R1");
    // R2 fetch in bank range still ROM
    access(16'h0100, 1'b1, 1'b1, 1'b0, "R2");
    access(16'h3FFF, 1'b1, 1'b1, 1'b0, "R2");
    // R4 bank boundaries and mirror
    access(16'h0100, 1'b0, 1'b1, 1'b0, "R4");
    access(16'h3FFF, 1'b0, 1'b0, 1'b1, "R4 mirror");
    loadPage(1'b0, 3'd7);
    access(16'h1FFF, 1'b0, 1'b1, 1'b0, "R4 bank7");
    loadPage(1'b0, 3'd0);
    access(16'h2000, 1'b0, 1'b1, 1'b0, "R3");
    // R5, R7
    access(16'h4000, 1'b1, 1'b1, 1'b0, "R5");
    access(16'h7FFF, 1'b0, 1'b0, 1'b1, "R5");
    access(16'hC000, 1'b0, 1'b1, 1'b0, "R7");
    access(16'hFFFF, 1'b1, 1'b0, 1'b1, "R7");
    // R6 / R10 upper page, including ignored value 0
    loadPage(1'b1, 3'd3);
    access(16'hBFFF, 1'b1, 1'b1, 1'b0, "R6 page3");
    loadPage(1'b1, 3'd0);
    access(16'h8000, 1'b0, 1'b1, 1'b0, "R10 zero ignored");
    loadPage(1'b1, 3'd2);
    access(16'h9ABC, 1'b0, 1'b0, 1'b1, "R6 page2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) loadPage(r[4], r[7:5]);
      access(r[31:16], r[8], r[9], r[10] & r[11], "random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule